// File: doc/BRIEF.md
# L2 Snoop Responder with L1 Intervention

This block is the bus-facing coherence responder of an inclusive second-level cache. It watches snooped read, read-exclusive and upgrade commands, each of which names a line index. It looks up the L2 state of that line, which is I, S or M. It answers on the bus with a snoop response that carries a wired-OR modified indication. The L2 never holds the newest copy of a dirty line, because dirty data always sits in L1. So when a snoop hits a modified line, the block sends an intervention to L1, waits for the L1 reply, and then hands the line to the bus over a valid/ready data port. A snoop that takes exclusive ownership of a shared line sends L1 an invalidate and moves the line to I.

L1 can evict a dirty line at the moment an intervention for it is in flight. The block watches the L1 writeback channel while the intervention is outstanding. If a writeback for the pending line arrives, the block records the race and keeps the writeback data. When the intervention reply comes back, it is treated as a miss and the saved writeback data goes to the bus instead. The local side loads line states through a fill port.

The controller is a single state machine with six states:
- IDLE accepts a snoop.
- WAIT counts the fixed response latency.
- IVN holds an intervention request to L1.
- REPLY waits for the L1 answer.
- FLUSH offers the line to the bus.
- INV holds an invalidate request to L1.

The transitions are:
- IDLE→WAIT when a snoop is accepted.
- WAIT→IVN when the line is M.
- WAIT→INV when the line is S and the command is exclusive.
- WAIT→IDLE when no action is needed.
- IVN→REPLY when L1 accepts the request.
- REPLY→FLUSH when the reply arrives for a read or read-exclusive.
- REPLY→IDLE when the reply arrives for an upgrade.
- FLUSH→IDLE when the bus takes the data.
- INV→IDLE when L1 accepts the invalidate.

Top module: `l2_snoop_responder`

## Requirements
- R1: After reset, `snp_busy`, `rsp_valid`, `l1_req_valid` and `bus_valid` are low, and every line is in state I.
- R2: A snoop is accepted in a cycle where `snp_valid` is high, `snp_busy` is low and `snp_op` is not 0. The op codes are 1 = read, 2 = read-exclusive and 3 = upgrade. After acceptance, `rsp_valid` is high for exactly one cycle, LAT cycles after the snoop cycle, and `snp_busy` is high from the next cycle until handling ends. A snoop offered while busy, or with op 0, is ignored and produces no response.
- R3: A read snoop to a line in I or S gives `rsp_mod`=0 and sends no L1 request. The line state is unchanged, and `snp_busy` is low in the cycle after the response.
- R4: A read snoop to a line in M gives `rsp_mod`=1. In the cycle after the response, an L1 request of kind 1 (read intervention) is raised for that index and held stable until `l1_req_ready`. The cycle after the L1 reply, `bus_valid` rises with the reply data and is held until `bus_ready`. The line ends in S.
- R5: A read-exclusive snoop to a line in S gives `rsp_mod`=0. In the cycle after the response it raises an L1 request of kind 3 (invalidate) for that index, and the line ends in I.
- R6: A read-exclusive snoop to a line in M gives `rsp_mod`=1. It raises an L1 request of kind 2 (read-exclusive intervention), places the reply data on the bus as in R4, and the line ends in I.
- R7: An upgrade snoop acts like read-exclusive in R5 and R6, but it never raises `bus_valid`. After the L1 reply to an intervention, `snp_busy` is low in the next cycle.
- R8: An L1 writeback (`l1_wb_valid`) whose index equals the pending intervention index can arrive at any time from the cycle the intervention request is first raised through the cycle of the L1 reply. In that case the bus receives the writeback data in place of the reply data.
- R9: A writeback to any other index during an intervention has no effect, and the bus receives the L1 reply data.
- R10: A fill (`fill_valid`) writes the line state given on `fill_state` (0 = I, 1 = S, 2 = M) for `fill_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Write a line state from the local side |
| fill_idx | input | IDX_W | Line index for the fill |
| fill_state | input | 2 | State to write (0 I, 1 S, 2 M) |
| snp_valid | input | 1 | Snooped command present |
| snp_op | input | 2 | Snooped command (1 read, 2 read-exclusive, 3 upgrade) |
| snp_idx | input | IDX_W | Line index of the snooped command |
| snp_busy | output | 1 | Responder is handling a snoop |
| rsp_valid | output | 1 | Snoop response cycle |
| rsp_mod | output | 1 | Wired-OR modified indication |
| l1_req_valid | output | 1 | Request to L1 pending |
| l1_req_kind | output | 2 | 1 read intervention, 2 read-exclusive intervention, 3 invalidate |
| l1_req_idx | output | IDX_W | Line index of the L1 request |
| l1_req_ready | input | 1 | L1 accepts the request |
| l1_rsp_valid | input | 1 | L1 intervention reply |
| l1_rsp_data | input | DATA_W | Data returned by L1 |
| l1_wb_valid | input | 1 | L1 dirty writeback |
| l1_wb_idx | input | IDX_W | Line index of the writeback |
| l1_wb_data | input | DATA_W | Writeback data |
| bus_valid | output | 1 | Line data offered to the bus |
| bus_data | output | DATA_W | Line data |
| bus_ready | input | 1 | Bus takes the data |

## Verification
The snoop response is due exactly LAT cycles after the cycle in which the snoop is presented. The bench sets the due cycle when it drives the snoop and compares `rsp_valid` and `rsp_mod` against it on every falling edge. An L1 request is due one cycle after the response, and bus data is due one cycle after the L1 reply. After the final handshake, or after a response that needs no action, `snp_busy` must be low one cycle later. The bench drives its inputs and samples these outputs on falling edges at those exact cycle counts, so every check lands in the cycle the result is due. Its line-state model is kept in integers and decides which action each snoop must produce.

// File: rtl/l2sr_pkg.sv
package l2sr_pkg;
    typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_t;
    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_RDX = 2'd2, OP_UPG = 2'd3} snp_op_t;
    typedef enum logic [1:0] {K_NONE = 2'd0, K_RD = 2'd1, K_RDX = 2'd2, K_INV = 2'd3} l1_kind_t;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_IVN, ST_REPLY, ST_FLUSH, ST_INV
    } fsm_t;
endpackage

// File: rtl/l2sr_state_array.sv
module l2sr_state_array
    import l2sr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_t         rd_st,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  line_st_t         upd_st,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  line_st_t         fill_st
);
    localparam int NLINES = 1 << IDX_W;

    line_st_t lines_q [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines_q[g] <= LS_I;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                lines_q[g] <= upd_st;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                lines_q[g] <= fill_st;
            end
        end
    end

    assign rd_st = lines_q[rd_idx];
endmodule

// File: rtl/l2sr_race_tracker.sv
module l2sr_race_tracker #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window,
    input  logic [IDX_W-1:0]  pend_idx,
    input  logic              clr,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    output logic              race,
    output logic [DATA_W-1:0] race_data
);
    logic              race_q;
    logic [DATA_W-1:0] wb_q;
    logic              hit_now;

    assign hit_now = window && wb_valid && (wb_idx == pend_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            race_q <= 1'b0;
            wb_q   <= '0;
        end else begin
            if (clr) begin
                race_q <= 1'b0;
            end else if (hit_now) begin
                race_q <= 1'b1;
            end
            if (hit_now) begin
                wb_q <= wb_data;
            end
        end
    end

    assign race      = race_q || hit_now;
    assign race_data = hit_now ? wb_data : wb_q;
endmodule

// File: rtl/l2_snoop_responder.sv
module l2_snoop_responder
    import l2sr_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [1:0]        fill_state,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic              snp_busy,
    output logic              rsp_valid,
    output logic              rsp_mod,
    output logic              l1_req_valid,
    output logic [1:0]        l1_req_kind,
    output logic [IDX_W-1:0]  l1_req_idx,
    input  logic              l1_req_ready,
    input  logic              l1_rsp_valid,
    input  logic [DATA_W-1:0] l1_rsp_data,
    input  logic              l1_wb_valid,
    input  logic [IDX_W-1:0]  l1_wb_idx,
    input  logic [DATA_W-1:0] l1_wb_data,
    output logic              bus_valid,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ready
);
    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT);

    fsm_t              state_q, state_d;
    snp_op_t           op_q;
    logic [IDX_W-1:0]  idx_q;
    line_st_t          st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] dat_q;

    line_st_t          rd_st;
    logic              accept;
    logic              lat_done;
    logic              upd_en;
    line_st_t          upd_st;
    logic              window;
    logic              reply_take;
    logic              race;
    logic [DATA_W-1:0] race_data;

    assign accept     = (state_q == ST_IDLE) && snp_valid && (snp_op != OP_NONE);
    assign lat_done   = (state_q == ST_WAIT) && (cnt_q == '0);
    assign reply_take = (state_q == ST_REPLY) && l1_rsp_valid;

    l2sr_state_array #(.IDX_W(IDX_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (snp_idx),
        .rd_st    (rd_st),
        .upd_en   (upd_en),
        .upd_idx  (idx_q),
        .upd_st   (upd_st),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_st  (line_st_t'(fill_state))
    );

    l2sr_race_tracker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_race (
        .clk       (clk),
        .rst_n     (rst_n),
        .window    (window),
        .pend_idx  (idx_q),
        .clr       (reply_take),
        .wb_valid  (l1_wb_valid),
        .wb_idx    (l1_wb_idx),
        .wb_data   (l1_wb_data),
        .race      (race),
        .race_data (race_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Snoop context and returned line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            idx_q <= '0;
            st_q  <= LS_I;
            cnt_q <= '0;
            dat_q <= '0;
        end else begin
            if (accept) begin
                op_q  <= snp_op_t'(snp_op);
                idx_q <= snp_idx;
                st_q  <= rd_st;
                cnt_q <= CNT_W'(LAT - 1);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (reply_take) begin
                dat_q <= race ? race_data : l1_rsp_data;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_WAIT;
            ST_WAIT: begin
                if (lat_done) begin
                    if (st_q == LS_M) begin
                        state_d = ST_IVN;
                    end else if (st_q == LS_S && op_q != OP_RD) begin
                        state_d = ST_INV;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IVN:   if (l1_req_ready) state_d = ST_REPLY;
            ST_REPLY: begin
                if (l1_rsp_valid) begin
                    state_d = (op_q == OP_UPG) ? ST_IDLE : ST_FLUSH;
                end
            end
            ST_FLUSH: if (bus_ready) state_d = ST_IDLE;
            ST_INV:   if (l1_req_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        snp_busy     = (state_q != ST_IDLE);
        rsp_valid    = lat_done;
        rsp_mod      = lat_done && (st_q == LS_M);
        l1_req_valid = (state_q == ST_IVN) || (state_q == ST_INV);
        l1_req_idx   = idx_q;
        if (state_q == ST_INV) begin
            l1_req_kind = K_INV;
        end else if (state_q == ST_IVN) begin
            l1_req_kind = (op_q == OP_RD) ? K_RD : K_RDX;
        end else begin
            l1_req_kind = K_NONE;
        end
        bus_valid = (state_q == ST_FLUSH);
        bus_data  = dat_q;
        window    = (state_q == ST_IVN) || (state_q == ST_REPLY);
        upd_en    = 1'b0;
        upd_st    = LS_I;
        if (lat_done && st_q == LS_S && op_q != OP_RD) begin
            upd_en = 1'b1;
            upd_st = LS_I;
        end else if (reply_take) begin
            upd_en = 1'b1;
            upd_st = (op_q == OP_RD) ? LS_S : LS_I;
        end
    end
endmodule

// File: rtl/l2sr_checker.sv
module l2sr_checker #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic              snp_busy,
    input logic              rsp_valid,
    input logic              rsp_mod,
    input logic              l1_req_valid,
    input logic [1:0]        l1_req_kind,
    input logic [IDX_W-1:0]  l1_req_idx,
    input logic              l1_req_ready,
    input logic              bus_valid,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_ready
);
    logic accepted;
    logic pend_q;
    int   age_q;

    assign accepted = snp_valid && !snp_busy && (snp_op != 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            age_q  <= 0;
        end else if (accepted) begin
            pend_q <= 1'b1;
            age_q  <= 1;
        end else if (rsp_valid) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            age_q <= age_q + 1;
        end
    end

    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pend_q && age_q == LAT));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> snp_busy);

    p_mod_with_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mod |-> rsp_valid);

    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req_valid && !l1_req_ready) |=>
            (l1_req_valid && $stable(l1_req_kind) && $stable(l1_req_idx)));

    p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data)));

    p_one_channel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, l1_req_valid, bus_valid}));
endmodule

bind l2_snoop_responder l2sr_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LAT(LAT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_valid    (snp_valid),
    .snp_op       (snp_op),
    .snp_busy     (snp_busy),
    .rsp_valid    (rsp_valid),
    .rsp_mod      (rsp_mod),
    .l1_req_valid (l1_req_valid),
    .l1_req_kind  (l1_req_kind),
    .l1_req_idx   (l1_req_idx),
    .l1_req_ready (l1_req_ready),
    .bus_valid    (bus_valid),
    .bus_data     (bus_data),
    .bus_ready    (bus_ready)
);

// File: tb/sim_l2_snoop_responder.sv
`timescale 1ns/1ps
module sim_l2_snoop_responder;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 32;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fill_valid = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [1:0]        fill_state = '0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_op = '0;
    logic [IDX_W-1:0]  snp_idx = '0;
    logic              snp_busy, rsp_valid, rsp_mod;
    logic              l1_req_valid;
    logic [1:0]        l1_req_kind;
    logic [IDX_W-1:0]  l1_req_idx;
    logic              l1_req_ready = 1'b0;
    logic              l1_rsp_valid = 1'b0;
    logic [DATA_W-1:0] l1_rsp_data = '0;
    logic              l1_wb_valid = 1'b0;
    logic [IDX_W-1:0]  l1_wb_idx = '0;
    logic [DATA_W-1:0] l1_wb_data = '0;
    logic              bus_valid;
    logic [DATA_W-1:0] bus_data;
    logic              bus_ready = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0, due = -1;
    bit exp_mod = 1'b0, done = 1'b0;
    int ref_st [16];

    always #2 clk = ~clk;

    l2_snoop_responder #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LAT(LAT)) u0 (.*);

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference comparison of the response channel on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid === (cyc == due), "R2 response timing", rsp_valid, cyc == due);
            if (cyc == due) chk(rsp_mod === exp_mod, "R3/R4 modified indication", rsp_mod, exp_mod);
        end
    end

    task automatic fill(input int idx, input int st);
        fill_valid = 1'b1; fill_idx = IDX_W'(idx); fill_state = 2'(st);
        @(negedge clk);
        fill_valid = 1'b0;
        ref_st[idx] = st;
    endtask

    // op: 1 read, 2 read-exclusive, 3 upgrade
    task automatic snoop(input int op, input int idx, input string tag,
                         input bit wb_en, input int wb_idx, input logic [DATA_W-1:0] wb_dat,
                         input logic [DATA_W-1:0] rdat, input bit busy_snoop);
        int act;
        logic [DATA_W-1:0] exp_dat;
        snp_valid = 1'b1; snp_op = 2'(op); snp_idx = IDX_W'(idx);
        due = cyc + LAT;
        exp_mod = (ref_st[idx] == 2);
        act = (ref_st[idx] == 2) ? 2 : ((ref_st[idx] == 1 && op != 1) ? 1 : 0);
        if (ref_st[idx] == 2) ref_st[idx] = (op == 1) ? 1 : 0;
        else if (ref_st[idx] == 1 && op != 1) ref_st[idx] = 0;
        @(negedge clk);
        snp_valid = 1'b0;
        while (cyc < due) @(negedge clk);
        @(negedge clk);
        if (act == 0) begin
            chk(l1_req_valid === 1'b0, {tag, " no L1 request"}, l1_req_valid, 0);
            chk(snp_busy === 1'b0, {tag, " idle after response"}, snp_busy, 0);
        end else if (act == 1) begin
            chk(l1_req_valid === 1'b1 && l1_req_kind === 2'd3 && l1_req_idx === IDX_W'(idx),
                {tag, " invalidate request"}, {l1_req_valid, l1_req_kind, l1_req_idx}, {1'b1, 2'd3, IDX_W'(idx)});
            @(negedge clk);
            l1_req_ready = 1'b1;
            @(negedge clk);
            l1_req_ready = 1'b0;
            chk(snp_busy === 1'b0, {tag, " idle after invalidate"}, snp_busy, 0);
        end else begin
            chk(l1_req_valid === 1'b1 && l1_req_kind === ((op == 1) ? 2'd1 : 2'd2) && l1_req_idx === IDX_W'(idx),
                {tag, " intervention request"}, {l1_req_valid, l1_req_kind, l1_req_idx},
                {1'b1, (op == 1) ? 2'd1 : 2'd2, IDX_W'(idx)});
            @(negedge clk);
            l1_req_ready = 1'b1;
            @(negedge clk);
            l1_req_ready = 1'b0;
            if (busy_snoop) begin
                snp_valid = 1'b1; snp_op = 2'd1; snp_idx = 4'd3;
                @(negedge clk);
                snp_valid = 1'b0;
                chk(snp_busy === 1'b1, "R2 busy while reply pending", snp_busy, 1);
            end
            if (wb_en) begin
                l1_wb_valid = 1'b1; l1_wb_idx = IDX_W'(wb_idx); l1_wb_data = wb_dat;
                @(negedge clk);
                l1_wb_valid = 1'b0;
            end
            l1_rsp_valid = 1'b1; l1_rsp_data = rdat;
            @(negedge clk);
            l1_rsp_valid = 1'b0;
            exp_dat = (wb_en && wb_idx == idx) ? wb_dat : rdat;
            if (op == 3) begin
                chk(bus_valid === 1'b0, "R7 upgrade has no flush", bus_valid, 0);
                chk(snp_busy === 1'b0, "R7 idle after upgrade reply", snp_busy, 0);
            end else begin
                chk(bus_valid === 1'b1 && bus_data === exp_dat, {tag, " line on bus"},
                    {bus_valid, bus_data}, {1'b1, exp_dat});
                @(negedge clk);
                chk(bus_valid === 1'b1 && bus_data === exp_dat, {tag, " bus data held"},
                    bus_data, exp_dat);
                bus_ready = 1'b1;
                @(negedge clk);
                bus_ready = 1'b0;
                chk(snp_busy === 1'b0, {tag, " idle after flush"}, snp_busy, 0);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        foreach (ref_st[i]) ref_st[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(snp_busy === 0 && rsp_valid === 0 && l1_req_valid === 0 && bus_valid === 0,
            "R1 reset outputs", {snp_busy, rsp_valid, l1_req_valid, bus_valid}, 0);
        // R10 fills
        fill(3, 1); fill(5, 2); fill(6, 2); fill(7, 1); fill(8, 2); fill(9, 2); fill(10, 2);
        // R1 untouched line is I: read-exclusive needs no action
        snoop(2, 0, "R1", 0, 0, 0, 0, 0);
        // R2 op 0 ignored
        snp_valid = 1'b1; snp_op = 2'd0; snp_idx = 4'd5;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_busy === 1'b0, "R2 op 0 ignored", snp_busy, 0);
        // R3 read on I and S
        snoop(1, 1, "R3", 0, 0, 0, 0, 0);
        snoop(1, 3, "R3", 0, 0, 0, 0, 0);
        // R4 read on M, then line is S
        snoop(1, 5, "R4", 0, 0, 0, 32'hA5A5_0005, 0);
        snoop(1, 5, "R4 now S", 0, 0, 0, 0, 0);
        snoop(2, 5, "R4 S then R5", 0, 0, 0, 0, 0);
        // R5 read-exclusive on S, then line is I
        snoop(2, 7, "R5", 0, 0, 0, 0, 0);
        snoop(2, 7, "R5 now I", 0, 0, 0, 0, 0);
        // R6 read-exclusive on M
        snoop(2, 6, "R6", 0, 0, 0, 32'h6666_0006, 0);
        snoop(2, 6, "R6 now I", 0, 0, 0, 0, 0);
        // R7 upgrade on M and on S
        snoop(3, 8, "R7", 0, 0, 0, 32'h8888_0008, 0);
        snoop(2, 8, "R7 now I", 0, 0, 0, 0, 0);
        snoop(3, 3, "R7 upgrade on S", 0, 0, 0, 0, 0);
        // R8 racing writeback; also a snoop while busy (R2)
        snoop(1, 9, "R8", 1, 9, 32'hB0B0_0009, 32'hDEAD_0009, 1);
        // R9 writeback to another line
        fill(4, 2);
        snoop(2, 10, "R9", 1, 2, 32'hC0C0_0002, 32'h1010_000A, 0);
        // R8 writeback arriving with request still unaccepted is covered by window; repeat race on read-exclusive
        snoop(2, 4, "R8 read-exclusive", 1, 4, 32'hF00D_0004, 32'hBAD0_0004, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule